// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit holds the two length controls of a scalar core that carries a vector extension. The first is the maximum vector length, which software can change. The second is the active vector length. The unit also carries out the set-length instruction. It accepts CSR reads and writes for two views. One view holds only the maximum-length field. The other is a packed state word that also carries the destination and source element offsets, so that a context switch can save and restore everything with one access.

The maximum length ranges from 1 to XLEN, and the unit stores it as the value minus one. With that encoding, log2(XLEN) bits cover the whole range. A set-length request supplies a requested length and a destination register index. The unit grants exactly the requested length when it lies between 1 and the maximum. A request above the maximum is cut down to the maximum, and a request of zero is raised to one. The unit has no freedom to pick any other value. The granted length comes back one cycle later with a valid pulse and a writeback enable. The writeback enable is held low when the destination is register zero.

Top module: `vl_config_unit`

## Requirements
- R1: After reset the maximum length is 1, the active length is 1 and both element offsets are 0. Both CSR views therefore read as 0, `mvl_out` reads 1 and `vl_out` reads 1.
- R2: A write to the maximum-length view (`csr_sel`=0) stores `csr_wdata[log2(XLEN)-1:0]` as maximum-minus-one. A read of that view returns the stored code in bits [5:0], with every other bit 0. `mvl_out` then shows the stored code plus one.
- R3: A set-length request with 1 <= `setvl_len` <= maximum grants exactly `setvl_len`. A request above the maximum grants the maximum.
- R4: A set-length request with `setvl_len` = 0 grants 1.
- R5: The result of a request appears on the clock edge after the request. `setvl_valid` is high for exactly one cycle, and `setvl_vl` and `vl_out` both carry the granted length.
- R6: With the result, `setvl_rd_idx` repeats the requested register index. `setvl_rd_we` is 1 unless that index is 0, in which case it is 0.
- R7: The state view (`csr_sel`=1) uses this layout: maximum-minus-one in bits [5:0], active-length-minus-one in bits [11:6], destination offset in bits [17:12] and source offset in bits [23:18]. Bits above 23 read as 0. A write to this view sets all four fields, and a read returns them.
- R8: A write to the maximum-length view that makes the maximum smaller than the active length also lowers the active length to the new maximum, on the same edge.
- R9: A state-view write whose active-length field is above its maximum field stores the active length equal to the maximum.
- R10: When a set-length request and a CSR write arrive in the same cycle, the request is carried out and the CSR write is discarded.
- R11: At every cycle, 1 <= `vl_out` <= `mvl_out` <= XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_sel | input | 1 | View select: 0 maximum length, 1 packed state |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for the selected view, combinational |
| setvl_req | input | 1 | Set-length request |
| setvl_len | input | XLEN | Requested length |
| setvl_rd | input | 5 | Destination register index |
| setvl_valid | output | 1 | One-cycle result pulse |
| setvl_vl | output | XLEN | Granted length |
| setvl_rd_we | output | 1 | Destination writeback enable |
| setvl_rd_idx | output | 5 | Destination register index of the result |
| mvl_out | output | log2(XLEN)+1 | Current maximum length (decoded) |
| vl_out | output | log2(XLEN)+1 | Current active length (decoded) |

## Verification
A CSR write takes effect on the edge that samples it. The read view is combinational, so the bench reads it at the falling edge that follows the write. A set-length result is registered once. The bench drives a request at one falling edge and checks `setvl_valid`, `setvl_vl`, `setvl_rd_we` and `vl_out` at the next falling edge, which comes after the single capturing edge. One cycle later it checks that the valid pulse has dropped. Every input change is made at a falling edge, so no check depends on the order of processes at the rising edge.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

    // Width of each packed field slot in the state view
    localparam int SLOT_W  = 6;
    localparam int PACK_W  = 4 * SLOT_W;

    typedef enum logic {
        CSR_MVL   = 1'b0,
        CSR_STATE = 1'b1
    } csr_sel_e;

    // Packed order gives: mvl_m1 [5:0], vl_m1 [11:6], doff [17:12], soff [23:18]
    typedef struct packed {
        logic [SLOT_W-1:0] soff;
        logic [SLOT_W-1:0] doff;
        logic [SLOT_W-1:0] vl_m1;
        logic [SLOT_W-1:0] mvl_m1;
    } vl_state_t;

    localparam vl_state_t STATE_RESET = '{soff: '0, doff: '0, vl_m1: '0, mvl_m1: '0};

    function automatic logic [SLOT_W-1:0] slot_min(input logic [SLOT_W-1:0] a,
                                                   input logic [SLOT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [SLOT_W-1:0] field_mask(input int fw);
        return SLOT_W'((64'd1 << fw) - 64'd1);
    endfunction

endpackage

// File: rtl/vl_len_clamp.sv
module vl_len_clamp
    import vlcfg_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int FIELD_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]   req_len,
    input  logic [SLOT_W-1:0] mvl_m1,
    output logic [SLOT_W-1:0] grant_m1
);
    localparam logic [SLOT_W-1:0] FMASK = field_mask(FIELD_W);

    logic [XLEN-1:0] mvl_wide;
    logic [XLEN-1:0] len_dec;

    always_comb begin
        mvl_wide = XLEN'(mvl_m1 & FMASK) + XLEN'(1);
        len_dec  = req_len - XLEN'(1);
        if (req_len == '0) begin
            grant_m1 = '0;
        end else if (req_len > mvl_wide) begin
            grant_m1 = mvl_m1 & FMASK;
        end else begin
            grant_m1 = len_dec[SLOT_W-1:0] & FMASK;
        end
    end

endmodule

// File: rtl/vl_state_next.sv
module vl_state_next
    import vlcfg_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int FIELD_W = $clog2(XLEN)
) (
    input  vl_state_t         cur,
    input  logic              wr_en,
    input  csr_sel_e          sel,
    input  logic [XLEN-1:0]   wdata,
    input  logic              setvl_req,
    input  logic [SLOT_W-1:0] grant_m1,
    output vl_state_t         nxt
);
    localparam logic [SLOT_W-1:0] FMASK = field_mask(FIELD_W);

    vl_state_t         wr_fields;
    logic [SLOT_W-1:0] new_mvl;

    always_comb begin
        wr_fields = vl_state_t'(wdata[PACK_W-1:0]);
        new_mvl   = wdata[SLOT_W-1:0] & FMASK;
        nxt       = cur;
        if (setvl_req) begin
            nxt.vl_m1 = grant_m1;
        end else if (wr_en) begin
            if (sel == CSR_MVL) begin
                nxt.mvl_m1 = new_mvl;
                nxt.vl_m1  = slot_min(cur.vl_m1, new_mvl);
            end else begin
                nxt.mvl_m1 = wr_fields.mvl_m1 & FMASK;
                nxt.vl_m1  = slot_min(wr_fields.vl_m1 & FMASK, wr_fields.mvl_m1 & FMASK);
                nxt.doff   = wr_fields.doff & FMASK;
                nxt.soff   = wr_fields.soff & FMASK;
            end
        end
    end

endmodule

// File: rtl/vl_csr_view.sv
module vl_csr_view
    import vlcfg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  vl_state_t       st,
    input  csr_sel_e        sel,
    output logic [XLEN-1:0] rdata
);
    always_comb begin
        if (sel == CSR_MVL) begin
            rdata = XLEN'(st.mvl_m1);
        end else begin
            rdata = XLEN'(st);
        end
    end

endmodule

// File: rtl/vl_config_unit.sv
module vl_config_unit
    import vlcfg_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5,
    localparam int FIELD_W = $clog2(XLEN),
    localparam int CNT_W   = FIELD_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr_en,
    input  logic              csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic              setvl_req,
    input  logic [XLEN-1:0]   setvl_len,
    input  logic [RIDX_W-1:0] setvl_rd,
    output logic              setvl_valid,
    output logic [XLEN-1:0]   setvl_vl,
    output logic              setvl_rd_we,
    output logic [RIDX_W-1:0] setvl_rd_idx,
    output logic [CNT_W-1:0]  mvl_out,
    output logic [CNT_W-1:0]  vl_out
);
    vl_state_t         state_q;
    vl_state_t         state_d;
    logic [SLOT_W-1:0] grant_m1;
    csr_sel_e          sel_e;

    assign sel_e = csr_sel_e'(csr_sel);

    vl_len_clamp #(.XLEN(XLEN), .FIELD_W(FIELD_W)) u_clamp (
        .req_len  (setvl_len),
        .mvl_m1   (state_q.mvl_m1),
        .grant_m1 (grant_m1)
    );

    vl_state_next #(.XLEN(XLEN), .FIELD_W(FIELD_W)) u_next (
        .cur       (state_q),
        .wr_en     (csr_wr_en),
        .sel       (sel_e),
        .wdata     (csr_wdata),
        .setvl_req (setvl_req),
        .grant_m1  (grant_m1),
        .nxt       (state_d)
    );

    vl_csr_view #(.XLEN(XLEN)) u_view (
        .st    (state_q),
        .sel   (sel_e),
        .rdata (csr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= STATE_RESET;
            setvl_valid  <= 1'b0;
            setvl_vl     <= XLEN'(1);
            setvl_rd_we  <= 1'b0;
            setvl_rd_idx <= '0;
        end else begin
            state_q      <= state_d;
            setvl_valid  <= setvl_req;
            setvl_rd_we  <= setvl_req && (setvl_rd != '0);
            if (setvl_req) begin
                setvl_vl     <= XLEN'(grant_m1) + XLEN'(1);
                setvl_rd_idx <= setvl_rd;
            end
        end
    end

    assign mvl_out = CNT_W'(state_q.mvl_m1[FIELD_W-1:0]) + CNT_W'(1);
    assign vl_out  = CNT_W'(state_q.vl_m1[FIELD_W-1:0]) + CNT_W'(1);

endmodule

// File: rtl/vl_config_chk.sv
module vl_config_chk #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5,
    parameter int CNT_W  = $clog2(XLEN) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              setvl_req,
    input logic [XLEN-1:0]   setvl_len,
    input logic [RIDX_W-1:0] setvl_rd,
    input logic              setvl_valid,
    input logic [XLEN-1:0]   setvl_vl,
    input logic              setvl_rd_we,
    input logic [CNT_W-1:0]  mvl_out,
    input logic [CNT_W-1:0]  vl_out
);
    // R11
    vl_range_chk: assert property (@(posedge clk) disable iff (rst)
        (vl_out >= CNT_W'(1)) && (vl_out <= mvl_out));

    // R11
    mvl_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mvl_out >= CNT_W'(1)) && (32'(mvl_out) <= 32'(XLEN)));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        setvl_req |=> setvl_valid);

    // R5
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !setvl_req |=> !setvl_valid);

    // R5
    vl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        setvl_valid |-> (XLEN'(vl_out) == setvl_vl));

    // R6
    x0_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        (setvl_req && setvl_rd == '0) |=> !setvl_rd_we);

    // R3
    exact_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (setvl_req && setvl_len >= XLEN'(1) && setvl_len <= XLEN'(mvl_out))
        |=> (setvl_vl == $past(setvl_len)));

    // R4
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (setvl_req && setvl_len == '0) |=> (setvl_vl == XLEN'(1)));

endmodule

bind vl_config_unit vl_config_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .setvl_req   (setvl_req),
    .setvl_len   (setvl_len),
    .setvl_rd    (setvl_rd),
    .setvl_valid (setvl_valid),
    .setvl_vl    (setvl_vl),
    .setvl_rd_we (setvl_rd_we),
    .mvl_out     (mvl_out),
    .vl_out      (vl_out)
);

// File: tb/tb_vl_config_unit.sv
`timescale 1ns/1ps
module tb_vl_config_unit;
    localparam int XLEN  = 64;
    localparam int RW    = 5;
    localparam int CNT_W = 7;

    logic              clk = 1'b0;
    logic              rst;
    logic              csr_wr_en;
    logic              csr_sel;
    logic [XLEN-1:0]   csr_wdata;
    logic [XLEN-1:0]   csr_rdata;
    logic              setvl_req;
    logic [XLEN-1:0]   setvl_len;
    logic [RW-1:0]     setvl_rd;
    logic              setvl_valid;
    logic [XLEN-1:0]   setvl_vl;
    logic              setvl_rd_we;
    logic [RW-1:0]     setvl_rd_idx;
    logic [CNT_W-1:0]  mvl_out;
    logic [CNT_W-1:0]  vl_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    vl_config_unit #(.XLEN(XLEN), .RIDX_W(RW)) dut (
        .clk(clk), .rst(rst),
        .csr_wr_en(csr_wr_en), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .setvl_req(setvl_req), .setvl_len(setvl_len), .setvl_rd(setvl_rd),
        .setvl_valid(setvl_valid), .setvl_vl(setvl_vl), .setvl_rd_we(setvl_rd_we),
        .setvl_rd_idx(setvl_rd_idx), .mvl_out(mvl_out), .vl_out(vl_out)
    );

    typedef struct packed {
        logic [5:0]      mvl_m1;
        logic [XLEN-1:0] len;
        logic [RW-1:0]   rd;
        logic [6:0]      exp_vl;
        logic            exp_we;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'd7,  64'd5,    5'd3,  7'd5,  1'b1},
        '{6'd7,  64'd8,    5'd1,  7'd8,  1'b1},
        '{6'd7,  64'd9,    5'd2,  7'd8,  1'b1},
        '{6'd63, 64'd64,   5'd31, 7'd64, 1'b1},
        '{6'd63, 64'd1000, 5'd4,  7'd64, 1'b1},
        '{6'd0,  64'd7,    5'd5,  7'd1,  1'b1},
        '{6'd15, 64'd0,    5'd6,  7'd1,  1'b1},
        '{6'd15, 64'd12,   5'd0,  7'd12, 1'b0},
        '{6'd31, 64'hFFFF_FFFF_FFFF_FFFF, 5'd9, 7'd32, 1'b1}
    };

    function automatic logic [XLEN-1:0] pack_state(input int mvl_m1, input int vl_m1,
                                                   input int doff, input int soff);
        return XLEN'(mvl_m1) | (XLEN'(vl_m1) << 6) | (XLEN'(doff) << 12) | (XLEN'(soff) << 18);
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic sel, input logic [XLEN-1:0] data);
        @(negedge clk);
        csr_wr_en = 1'b1; csr_sel = sel; csr_wdata = data;
        @(negedge clk);
        csr_wr_en = 1'b0; csr_wdata = '0;
    endtask

    task automatic csr_read(input logic sel, output logic [XLEN-1:0] data);
        csr_sel = sel;
        #1;
        data = csr_rdata;
    endtask

    task automatic setvl(input logic [XLEN-1:0] len, input logic [RW-1:0] rd);
        @(negedge clk);
        setvl_req = 1'b1; setvl_len = len; setvl_rd = rd;
        @(negedge clk);
        setvl_req = 1'b0; setvl_len = '0; setvl_rd = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] rd_v;
        rst = 1'b1; csr_wr_en = 1'b0; csr_sel = 1'b0; csr_wdata = '0;
        setvl_req = 1'b0; setvl_len = '0; setvl_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        csr_read(1'b0, rd_v); chk("R1 mvl view", rd_v, '0);
        csr_read(1'b1, rd_v); chk("R1 state view", rd_v, '0);
        chk("R1 mvl_out", XLEN'(mvl_out), 64'd1);
        chk("R1 vl_out", XLEN'(vl_out), 64'd1);
        chk("R1 valid", XLEN'(setvl_valid), 64'd0);

        // Vector table: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            csr_write(1'b0, XLEN'(VECS[i].mvl_m1));
            setvl(VECS[i].len, VECS[i].rd);
            chk("R5 valid", XLEN'(setvl_valid), 64'd1);
            chk("R3 granted vl", setvl_vl, XLEN'(VECS[i].exp_vl));
            chk("R5 vl_out", XLEN'(vl_out), XLEN'(VECS[i].exp_vl));
            chk("R6 rd_we", XLEN'(setvl_rd_we), XLEN'(VECS[i].exp_we));
            chk("R6 rd_idx", XLEN'(setvl_rd_idx), XLEN'(VECS[i].rd));
        end
        @(negedge clk);
        chk("R5 valid drops", XLEN'(setvl_valid), 64'd0);
        chk("R6 we drops", XLEN'(setvl_rd_we), 64'd0);

        // R2 upper write bits dropped
        csr_write(1'b0, 64'hFFFF_FFFF_FFFF_FFC5);
        csr_read(1'b0, rd_v); chk("R2 mvl view", rd_v, 64'd5);
        chk("R2 mvl_out", XLEN'(mvl_out), 64'd6);

        // R8 shrink of maximum pulls VL down
        setvl(64'd6, 5'd1);
        chk("R8 vl before", XLEN'(vl_out), 64'd6);
        csr_write(1'b0, 64'd2);
        chk("R8 vl after", XLEN'(vl_out), 64'd3);
        csr_read(1'b1, rd_v); chk("R8 state view", rd_v, pack_state(2, 2, 0, 0));

        // R7 full state round trip
        csr_write(1'b1, pack_state(40, 20, 7, 9) | 64'h8000_0000_0F00_0000);
        csr_read(1'b1, rd_v); chk("R7 state view", rd_v, pack_state(40, 20, 7, 9));
        chk("R7 mvl_out", XLEN'(mvl_out), 64'd41);
        chk("R7 vl_out", XLEN'(vl_out), 64'd21);
        csr_read(1'b0, rd_v); chk("R7 mvl view", rd_v, 64'd40);

        // R9 VL field above maximum field
        csr_write(1'b1, pack_state(10, 30, 3, 4));
        csr_read(1'b1, rd_v); chk("R9 state view", rd_v, pack_state(10, 10, 3, 4));
        chk("R9 vl_out", XLEN'(vl_out), 64'd11);

        // R10 simultaneous request and CSR write
        @(negedge clk);
        setvl_req = 1'b1; setvl_len = 64'd5; setvl_rd = 5'd2;
        csr_wr_en = 1'b1; csr_sel = 1'b0; csr_wdata = 64'd0;
        @(negedge clk);
        setvl_req = 1'b0; csr_wr_en = 1'b0;
        chk("R10 vl granted", setvl_vl, 64'd5);
        chk("R10 mvl kept", XLEN'(mvl_out), 64'd11);
        csr_read(1'b1, rd_v); chk("R10 state view", rd_v, pack_state(10, 4, 3, 4));

        // R1 reset again from a loaded state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        csr_read(1'b1, rd_v); chk("R1 state after reset", rd_v, '0);
        chk("R1 vl after reset", XLEN'(vl_out), 64'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule